// File: doc/BRIEF.md
# Four-Source Masked Interrupt Controller

This block collects interrupt requests for a small 8-bit microcontroller core from four sources: an edge on an external pin, a one-cycle timer overflow pulse, a change on a four-bit group of upper port pins, and a one-cycle data-memory write-complete pulse. Each source owns a sticky flag that is set by hardware whatever the masks say. Software can read the flags, clear or set them, and choose which ones may interrupt through per-source enables and one global enable.

The CPU sees a level request that is the global enable ANDed with any flag whose enable is set. When the CPU acknowledges, the controller clears the global enable and presents the fixed vector address to be loaded as the new program counter. A return strobe sets the global enable again. A separate wake-up output reports any enabled pending flag regardless of the global enable, so that a sleeping core can resume. The external pin and the port nibble cross into the clock domain through synchronizer stages.

Top module: `quad_irq_ctrl`

## Requirements
- R1: After reset all flags, enables and the global enable are 0, the pin edge select is 1 (rising), so `ctl_rdata` reads 0x100 and `irq_req` and `wake` are 0.
- R2: A high `tmr_ovf` sets flag bit 1 and a high `wr_done` sets flag bit 3 at the next clock edge, whatever the enables and the global enable. Flags stay set until software changes them.
- R3: `ext_pin` passes two synchronizer flops. With edge select 1, a rising pin edge sets flag bit 0 at the third clock edge after the change; with edge select 0, a falling edge does so instead. The opposite edge leaves the flag unchanged.
- R4: `port_hi` passes two synchronizer flops. A `port_rd` pulse copies the synchronized value into a snapshot. Flag bit 2 is set at each clock edge where the synchronized value differs from the snapshot, so it cannot be cleared while the difference persists.
- R5: `wr_flags` loads flag bits from `ctl_wdata[3:0]`. When a hardware set of a bit coincides with the write, the bit ends up set.
- R6: `irq_req` is 1 exactly when the global enable is 1 and some flag bit and its enable bit are both 1.
- R7: `wake` is 1 exactly when some flag bit and its enable bit are both 1, independent of the global enable.
- R8: `irq_ack` clears the global enable at the next edge, with priority over `irq_ret` and `wr_ctrl`. An acknowledge while `irq_req` is 1 gives a one-cycle `vec_load` pulse in the next cycle with `vec_addr` equal to 0x0004.
- R9: `irq_ret` without `irq_ack` sets the global enable; an enabled flag left set makes `irq_req` rise right after the return.
- R10: `ctl_rdata` reads {global enable [9], edge select [8], enables [7:4], flags [3:0]}; `wr_ctrl` loads bits 9..4 of `ctl_wdata` into the same fields, enable bit order equal to flag bit order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | Timer overflow pulse |
| port_hi | input | 4 | Asynchronous upper port pins watched for change |
| port_rd | input | 1 | Port read strobe, refreshes the change snapshot |
| wr_done | input | 1 | Data-memory write-complete pulse |
| wr_flags | input | 1 | Write strobe for the flag field |
| wr_ctrl | input | 1 | Write strobe for global enable, edge select and enables |
| ctl_wdata | input | 10 | Control register write data |
| ctl_rdata | output | 10 | Control register read data |
| irq_ack | input | 1 | CPU acknowledge of the request |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the CPU |
| vec_load | output | 1 | One-cycle pulse: load `vec_addr` into the program counter |
| vec_addr | output | 13 | Interrupt vector address |
| wake | output | 1 | Wake-up request from any enabled pending flag |

## Verification
The assertions assume that `irq_ack` and `irq_ret` are one-cycle strobes driven synchronously and that `port_rd` is synchronous; the pin and nibble inputs may change at any time since they are synchronized inside. The edge-pulse property relies on the pin holding each level for at least one clock, which the stimulus respects by holding every pin level for several cycles. The stimulus changes the edge select only while the synchronized pin is steady, so no spurious edge is created, and it raises acknowledge only as a single-cycle pulse.

// File: rtl/quad_irq_pkg.sv
package quad_irq_pkg;
  localparam int SRC_N   = 4;
  localparam int CTL_W   = 10;
  localparam int IDX_PIN = 0;
  localparam int IDX_TMR = 1;
  localparam int IDX_NIB = 2;
  localparam int IDX_WRD = 3;
  localparam int EN_LO   = 4;
  localparam int EDGE_B  = 8;
  localparam int GIE_B   = 9;

  function automatic logic any_armed(input logic [SRC_N-1:0] flg,
                                     input logic [SRC_N-1:0] ena);
    return |(flg & ena);
  endfunction

  function automatic logic [SRC_N-1:0] next_flags(input logic [SRC_N-1:0] cur,
                                                   input logic             wr,
                                                   input logic [SRC_N-1:0] wval,
                                                   input logic [SRC_N-1:0] hw);
    return (wr ? wval : cur) | hw;
  endfunction

  function automatic logic pick_edge(input logic rise, input logic now_v,
                                     input logic was_v);
    return rise ? (now_v & ~was_v) : (~now_v & was_v);
  endfunction
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_hit
);
  import quad_irq_pkg::*;

  logic [STAGES-1:0] sr;
  logic              prev;
  logic              cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '0;
      prev <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], pin};
      prev <= sr[STAGES-1];
    end
  end

  assign cur      = sr[STAGES-1];
  assign edge_hit = pick_edge(rise_sel, cur, prev);

  // R3: a held pin level gives at most a one-cycle edge pulse
  p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && $stable(rise_sel)) |=> !edge_hit);
endmodule

// File: rtl/irq_nib_change.sv
module irq_nib_change #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         snap_en,
  output logic         differs
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] snap;
  logic [W-1:0] cur;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) stg[g] <= '0;
        else if (g == 0) stg[g] <= pins;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign cur = stg[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n)       snap <= '0;
    else if (snap_en) snap <= cur;
  end

  assign differs = |(cur ^ snap);

  // R4: a read strobe captures the synchronized pins
  p_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> (snap == $past(cur)));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic         sw_wr,
  input  logic [N-1:0] sw_val,
  output logic [N-1:0] flags
);
  import quad_irq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= next_flags(flags, sw_wr, sw_val, hw_set);
  end

  // R5: a hardware set is never lost to a concurrent write
  p_hw_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set)));
  // R2: without a software write, set flags stay set
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/quad_irq_ctrl.sv
module quad_irq_ctrl #(
  parameter int          NIB_W  = 4,
  parameter int          SYNC_N = 2,
  parameter int          PC_W   = 13,
  parameter int unsigned VECTOR = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ext_pin,
  input  logic                           tmr_ovf,
  input  logic [NIB_W-1:0]               port_hi,
  input  logic                           port_rd,
  input  logic                           wr_done,
  input  logic                           wr_flags,
  input  logic                           wr_ctrl,
  input  logic [quad_irq_pkg::CTL_W-1:0] ctl_wdata,
  output logic [quad_irq_pkg::CTL_W-1:0] ctl_rdata,
  input  logic                           irq_ack,
  input  logic                           irq_ret,
  output logic                           irq_req,
  output logic                           vec_load,
  output logic [PC_W-1:0]                vec_addr,
  output logic                           wake
);
  import quad_irq_pkg::*;

  logic [SRC_N-1:0] flags;
  logic [SRC_N-1:0] ena;
  logic [SRC_N-1:0] hw_set;
  logic             gie;
  logic             rise_sel;
  logic             pin_hit;
  logic             nib_diff;
  logic             armed;

  irq_pin_edge #(.STAGES(SYNC_N)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_sel(rise_sel),
    .edge_hit(pin_hit)
  );

  irq_nib_change #(.W(NIB_W), .STAGES(SYNC_N)) u_nib (
    .clk(clk), .rst_n(rst_n), .pins(port_hi), .snap_en(port_rd),
    .differs(nib_diff)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[IDX_PIN] = pin_hit;
    hw_set[IDX_TMR] = tmr_ovf;
    hw_set[IDX_NIB] = nib_diff;
    hw_set[IDX_WRD] = wr_done;
  end

  irq_flag_bank #(.N(SRC_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_wr(wr_flags),
    .sw_val(ctl_wdata[SRC_N-1:0]), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena      <= '0;
      rise_sel <= 1'b1;
      gie      <= 1'b0;
      vec_load <= 1'b0;
    end else begin
      vec_load <= irq_ack & irq_req;
      if (wr_ctrl) begin
        ena      <= ctl_wdata[EN_LO +: SRC_N];
        rise_sel <= ctl_wdata[EDGE_B];
      end
      if (irq_ack)      gie <= 1'b0;
      else if (irq_ret) gie <= 1'b1;
      else if (wr_ctrl) gie <= ctl_wdata[GIE_B];
    end
  end

  assign armed     = any_armed(flags, ena);
  assign wake      = armed;
  assign irq_req   = gie & armed;
  assign vec_addr  = PC_W'(VECTOR);
  assign ctl_rdata = {gie, rise_sel, ena, flags};

  // R8: acknowledge drops the global enable
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !ctl_rdata[GIE_B]);
  // R8: an accepted request yields a vector load
  p_vec_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> (vec_load && vec_addr == PC_W'(VECTOR)));
  // R9: return restores the global enable
  p_ret_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack) |=> ctl_rdata[GIE_B]);
  // R7: any CPU request is also a wake-up
  p_req_wakes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);
  // R6: a cleared global enable blocks requests
  p_req_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[GIE_B] |-> !irq_req);
endmodule

// File: tb/quad_irq_ctrl_bench.sv
module quad_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0, tmr_ovf = 1'b0, port_rd = 1'b0, wr_done = 1'b0;
  logic [3:0] port_hi = '0;
  logic       wr_flags = 1'b0, wr_ctrl = 1'b0, irq_ack = 1'b0, irq_ret = 1'b0;
  logic [9:0] ctl_wdata = '0;
  logic [9:0] ctl_rdata;
  logic       irq_req, vec_load, wake;
  logic [12:0] vec_addr;

  typedef struct {
    string       tag;
    int          kind;   // 0 rdata, 1 irq_req, 2 wake, 3 vec_load, 4 vec_addr
    logic [15:0] exp;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sb_ev;
  int       n_cmp = 0, n_bad = 0;
  bit       done = 1'b0;

  always #10 clk = ~clk;

  quad_irq_ctrl u_quad_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .port_hi(port_hi), .port_rd(port_rd), .wr_done(wr_done),
    .wr_flags(wr_flags), .wr_ctrl(wr_ctrl), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .vec_load(vec_load), .vec_addr(vec_addr), .wake(wake)
  );

  function automatic logic [15:0] observe(int kind);
    case (kind)
      0:       return {6'd0, ctl_rdata};
      1:       return {15'd0, irq_req};
      2:       return {15'd0, wake};
      3:       return {15'd0, vec_load};
      default: return {3'd0, vec_addr};
    endcase
  endfunction

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [15:0] got;
        it  = sb_q.pop_front();
        got = observe(it.kind);
        n_cmp++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic expect_it(string tag, int kind, logic [15:0] exp);
    sb_item_t it;
    #1;
    it.tag = tag; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
    ->sb_ev;
    #1;
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wflags(logic [3:0] v);
    wr_flags = 1'b1; ctl_wdata = {6'd0, v};
    tick();
    wr_flags = 1'b0;
  endtask

  task automatic wctrl(logic [9:0] v);
    wr_ctrl = 1'b1; ctl_wdata = v;
    tick();
    wr_ctrl = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1'b1;
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    tick(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_it("R1 rdata", 0, 16'h100);
    expect_it("R1 req", 1, 0);
    expect_it("R1 wake", 2, 0);

    // R2 masked pulses set flags
    tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
    expect_it("R2 timer flag", 0, 16'h102);
    wr_done = 1'b1; tick(); wr_done = 1'b0;
    expect_it("R2 write-done flag", 0, 16'h10A);
    tick(3);
    expect_it("R2 sticky", 0, 16'h10A);
    expect_it("R6 masked no req", 1, 0);
    expect_it("R7 masked no wake", 2, 0);

    // R5 software write and collision
    wflags(4'h0);
    expect_it("R5 clear", 0, 16'h100);
    tmr_ovf = 1'b1; wflags(4'h0); tmr_ovf = 1'b0;
    expect_it("R5 hw wins", 0, 16'h102);
    wflags(4'h0);

    // R3 rising edge through two flops
    ext_pin = 1'b1;
    tick(2);
    expect_it("R3 not yet", 0, 16'h100);
    tick();
    expect_it("R3 rise sets", 0, 16'h101);
    wflags(4'h0);
    ext_pin = 1'b0; tick(4);
    expect_it("R3 fall ignored", 0, 16'h100);
    wctrl(10'h000);
    expect_it("R10 ctrl write", 0, 16'h000);
    ext_pin = 1'b1; tick(4);
    expect_it("R3 rise ignored", 0, 16'h000);
    ext_pin = 1'b0; tick(3);
    expect_it("R3 fall sets", 0, 16'h001);
    wflags(4'h0);

    // R4 nibble change
    tick(3);
    expect_it("R4 no change", 0, 16'h000);
    port_hi = 4'h5; tick(2);
    expect_it("R4 not yet", 0, 16'h000);
    tick();
    expect_it("R4 change sets", 0, 16'h004);
    wflags(4'h0);
    expect_it("R4 persists", 0, 16'h004);
    port_rd = 1'b1; tick(); port_rd = 1'b0;
    wflags(4'h0);
    expect_it("R4 cleared after read", 0, 16'h000);

    // R6..R10 request, ack, return
    wctrl(10'h310);
    expect_it("R10 layout", 0, 16'h310);
    expect_it("R6 no flag", 1, 0);
    wflags(4'h1);
    expect_it("R6 req", 1, 1);
    expect_it("R7 wake", 2, 1);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    expect_it("R8 vec_load", 3, 1);
    expect_it("R8 vec_addr", 4, 16'h0004);
    expect_it("R8 gie cleared", 0, 16'h111);
    expect_it("R6 req off", 1, 0);
    expect_it("R7 wake without gie", 2, 1);
    tick();
    expect_it("R8 one pulse", 3, 0);
    irq_ret = 1'b1; tick(); irq_ret = 1'b0;
    expect_it("R9 gie set", 0, 16'h311);
    expect_it("R9 re-request", 1, 1);
    irq_ack = 1'b1; irq_ret = 1'b1; tick(); irq_ack = 1'b0; irq_ret = 1'b0;
    expect_it("R8 ack beats ret", 0, 16'h111);
    irq_ret = 1'b1; tick(); irq_ret = 1'b0;
    irq_ack = 1'b1; wctrl(10'h310); irq_ack = 1'b0;
    expect_it("R8 ack beats write", 0, 16'h111);
    irq_ret = 1'b1; tick(); irq_ret = 1'b0;
    wflags(4'h2);
    expect_it("R6 other source masked", 0, 16'h312);
    expect_it("R6 masked req", 1, 0);
    expect_it("R7 masked wake", 2, 0);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    expect_it("R8 no vec without req", 3, 0);

    tick(2);
    if (!done) begin
      done = 1'b1;
      finish_run();
    end
  end
endmodule